// File: doc/BRIEF.md
# Serial ADC Device-Side Sequencer

This block is the digital sequencer on the converter side of a three-wire serial sampling ADC. A host drives a serial clock and an active-low chip-select. The block counts serial-clock falling edges from the start of each frame, and that count times everything else. It opens a sample window and runs a conversion phase that takes a 12-bit code from an input port. It shifts the result of the previous conversion out MSB first, and it raises a power-down flag when a conversion ends. It also keeps a two-channel input selection whose next value depends on how long the frame lasted.

The serial clock and chip-select arrive as ordinary inputs, already synchronised to a faster block clock `clk`. The block detects their edges internally, and every output is a register that changes one `clk` cycle after the input edge that caused it. The tri-state data pin appears as an output enable plus a data bit. If chip-select rises while a conversion is running, the conversion is abandoned. A flag is then set and the next frame shifts out zeros in place of a result.

Top module: `serial_adc_seq`

## Requirements
- R1: On a chip-select falling edge, `sdo_oe` goes high and `power_down` goes low. `sdo_data` then shows bit 15 of the 16-bit output word.
- R2: The output word is the stored 12-bit result in bits 15..4, with bits 3..0 zero. While chip-select is low, each serial-clock rising edge that follows the 1st to 15th falling edge advances `sdo_data` one bit toward bit 0. Before falling edge j (j = 1..16), `sdo_data` equals word bit 16-j.
- R3: `sdo_oe` drops on the rising edge that follows the 16th falling edge. It also drops on a chip-select rising edge and stays low while chip-select is high.
- R4: `sample_en` is high after the 4th through the 15th falling edge of a frame, which is 12 serial-clock periods, and low otherwise.
- R5: `converting` is high after the 16th through the 43rd falling edge, which is 28 periods. `conv_code` is captured on the 16th falling edge, and that value becomes the stored result on the 44th.
- R6: Each frame shifts out the result of the most recent conversion that completed.
- R7: A chip-select rise after 16 to 43 falling edges aborts the conversion: `converting` drops, `result_void` goes high and the stored result is kept. While `result_void` is high, the next frame shifts out an all-zero word.
- R8: `power_down` is high out of reset. It is set when a conversion completes and on any chip-select rise, and cleared on a chip-select fall.
- R9: On a chip-select rise, `channel` is cleared if the frame saw 4 to 7 falling edges, toggles if it saw 8 or more, and is unchanged if it saw fewer than 4. Its reset value is 0.
- R10: When the 44th falling edge and the chip-select rise fall in the same `clk` cycle, the conversion completes and is not aborted.
- R11: `result_void` clears when a later conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, synchronised to clk |
| cs_n | input | 1 | Active-low chip-select, synchronised to clk |
| conv_code | input | 12 | Code produced by the analog converter |
| sdo_data | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the serial data pin |
| sample_en | output | 1 | Sample window active |
| converting | output | 1 | Conversion phase active |
| power_down | output | 1 | Converter may power down |
| channel | output | 1 | Selected input channel |
| result_void | output | 1 | Last conversion was aborted |

## Verification
Two events can land on the same block clock edge. The final serial-clock falling edge completes a conversion, and a chip-select rise inside the conversion phase aborts one. The bench provokes the collision by driving the 44th falling edge and the chip-select rise in the same cycle. It judges the outcome from the next frame, which must shift out the code captured in that frame rather than zeros. It also checks `result_void`, which must stay low. A second class of collision is the chip-select edge against the channel rule, tested at frame lengths of 2, 5, 7, 8, 10 and 44 edges.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   localparam int unsigned ADCSEQ_CODE_W     = 12;
   localparam int unsigned ADCSEQ_FRAME_BITS = 16;
   localparam int unsigned ADCSEQ_SAMP_START = 4;
   localparam int unsigned ADCSEQ_SAMP_LEN   = 12;
   localparam int unsigned ADCSEQ_CONV_CLKS  = 28;
   localparam int unsigned ADCSEQ_CH_RST_LO  = 4;
   localparam int unsigned ADCSEQ_CH_RST_HI  = 7;

   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sclk_rise;
      logic sclk_fall;
   } adcseq_ev_t;
endpackage

// File: rtl/adcseq_edges.sv
module adcseq_edges #(
   parameter int unsigned CNT_W   = 6,
   parameter int unsigned CNT_MAX = 44
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sclk,
   input  logic                    cs_n,
   output adcseq_pkg::adcseq_ev_t  ev,
   output logic [CNT_W-1:0]        cnt_q,
   output logic [CNT_W-1:0]        cnt_nxt
);
   localparam logic [CNT_W-1:0] K_LIM = CNT_W'(CNT_MAX);

   generate
      if (CNT_MAX >= (2 ** CNT_W)) begin : g_bad_width
         $error("adcseq_edges: CNT_W too narrow for CNT_MAX");
      end
   endgenerate

   logic sclk_q;
   logic cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
         cnt_q  <= '0;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
         cnt_q  <= cnt_nxt;
      end
   end

   // serial-clock edges only count inside a frame (chip-select low last cycle)
   always_comb begin
      ev.cs_fall   = cs_q & ~cs_n;
      ev.cs_rise   = ~cs_q & cs_n;
      ev.sclk_rise = ~cs_q & sclk & ~sclk_q;
      ev.sclk_fall = ~cs_q & ~sclk & sclk_q;
   end

   always_comb begin
      if (ev.cs_fall)
         cnt_nxt = '0;
      else if (ev.sclk_fall && (cnt_q != K_LIM))
         cnt_nxt = cnt_q + 1'b1;
      else
         cnt_nxt = cnt_q;
   end
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned CNT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              cs_rise,
   input  logic              sclk_rise,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [DATA_W-1:0] word,
   output logic              sdo_data,
   output logic              sdo_oe
);
   localparam int unsigned      PAD_W  = FRAME_BITS - DATA_W;
   localparam logic [CNT_W-1:0] K_LAST = CNT_W'(FRAME_BITS);

   logic [FRAME_BITS-1:0] frame_word;
   logic [FRAME_BITS-1:0] shreg;

   generate
      if (FRAME_BITS < DATA_W || FRAME_BITS < 2) begin : g_bad_frame
         $error("adcseq_shifter: frame shorter than data word");
      end
      if (PAD_W == 0) begin : g_nopad
         assign frame_word = word;
      end else begin : g_pad
         assign frame_word = {word, {PAD_W{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         sdo_oe <= 1'b0;
      end else if (load) begin
         shreg  <= frame_word;
         sdo_oe <= 1'b1;
      end else if (cs_rise) begin
         sdo_oe <= 1'b0;
      end else if (sclk_rise) begin
         if (cnt_q == K_LAST)
            sdo_oe <= 1'b0;
         else if (cnt_q != '0 && cnt_q < K_LAST)
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign sdo_data = shreg[FRAME_BITS-1];

   // R3: no shifting once the enable has dropped for the frame
   p_no_shift_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdo_oe && !$past(load) && $past(!sdo_oe)) |-> $stable(shreg));
endmodule

// File: rtl/adcseq_chsel.sv
module adcseq_chsel #(
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned RST_LO = 4,
   parameter int unsigned RST_HI = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_rise,
   input  logic [CNT_W-1:0] frame_len,
   output logic             channel
);
   localparam logic [CNT_W-1:0] K_LO = CNT_W'(RST_LO);
   localparam logic [CNT_W-1:0] K_HI = CNT_W'(RST_HI);

   generate
      if (RST_LO > RST_HI) begin : g_bad_range
         $error("adcseq_chsel: reset range inverted");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         channel <= 1'b0;
      else if (cs_rise) begin
         if (frame_len > K_HI)
            channel <= ~channel;
         else if (frame_len >= K_LO)
            channel <= 1'b0;
      end
   end

   // R9: channel only moves on a frame end
   p_chan_at_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(channel) |-> $past(cs_rise));
endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq #(
   parameter int unsigned CODE_W     = adcseq_pkg::ADCSEQ_CODE_W,
   parameter int unsigned FRAME_BITS = adcseq_pkg::ADCSEQ_FRAME_BITS,
   parameter int unsigned SAMP_START = adcseq_pkg::ADCSEQ_SAMP_START,
   parameter int unsigned SAMP_LEN   = adcseq_pkg::ADCSEQ_SAMP_LEN,
   parameter int unsigned CONV_CLKS  = adcseq_pkg::ADCSEQ_CONV_CLKS,
   parameter int unsigned CH_RST_LO  = adcseq_pkg::ADCSEQ_CH_RST_LO,
   parameter int unsigned CH_RST_HI  = adcseq_pkg::ADCSEQ_CH_RST_HI
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic [CODE_W-1:0] conv_code,
   output logic              sdo_data,
   output logic              sdo_oe,
   output logic              sample_en,
   output logic              converting,
   output logic              power_down,
   output logic              channel,
   output logic              result_void
);
   localparam int unsigned CONV_END = FRAME_BITS + CONV_CLKS;
   localparam int unsigned CNT_W    = $clog2(CONV_END + 1);

   localparam logic [CNT_W-1:0] K_SAMP_LO = CNT_W'(SAMP_START);
   localparam logic [CNT_W-1:0] K_SAMP_HI = CNT_W'(SAMP_START + SAMP_LEN);
   localparam logic [CNT_W-1:0] K_CONV_LO = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] K_CONV_HI = CNT_W'(CONV_END);
   localparam logic [CNT_W-1:0] K_CAPTURE = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] K_DONE    = CNT_W'(CONV_END - 1);

   generate
      if (SAMP_START + SAMP_LEN > FRAME_BITS) begin : g_bad_samp
         $error("serial_adc_seq: sample window overruns output frame");
      end
      if (CONV_CLKS == 0) begin : g_bad_conv
         $error("serial_adc_seq: conversion length must be nonzero");
      end
   endgenerate

   adcseq_pkg::adcseq_ev_t ev;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       cnt_nxt;
   logic [CODE_W-1:0]      held_code;
   logic [CODE_W-1:0]      result_q;
   logic [CODE_W-1:0]      out_word;
   logic                   conv_window;
   logic                   conv_done;
   logic                   conv_capture;
   logic                   conv_abort;

   adcseq_edges #(.CNT_W(CNT_W), .CNT_MAX(CONV_END)) u_edges (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
      .ev(ev), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
   );

   // completion is judged on the count including an edge in this same cycle
   assign conv_window  = (cnt_nxt >= K_CONV_LO) && (cnt_nxt < K_CONV_HI);
   assign conv_done    = ev.sclk_fall && (cnt_q == K_DONE);
   assign conv_capture = ev.sclk_fall && (cnt_q == K_CAPTURE);
   assign conv_abort   = ev.cs_rise && conv_window;
   assign out_word     = result_void ? '0 : result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_en   <= 1'b0;
         converting  <= 1'b0;
         power_down  <= 1'b1;
         held_code   <= '0;
         result_q    <= '0;
         result_void <= 1'b0;
      end else begin
         sample_en  <= ~cs_n && (cnt_nxt >= K_SAMP_LO) && (cnt_nxt < K_SAMP_HI);
         converting <= ~cs_n && conv_window;
         if (conv_capture)
            held_code <= conv_code;
         if (conv_done) begin
            result_q    <= held_code;
            result_void <= 1'b0;
         end else if (conv_abort) begin
            result_void <= 1'b1;
         end
         if (ev.cs_fall)
            power_down <= 1'b0;
         else if (conv_done || ev.cs_rise)
            power_down <= 1'b1;
      end
   end

   adcseq_shifter #(.DATA_W(CODE_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(ev.cs_fall), .cs_rise(ev.cs_rise),
      .sclk_rise(ev.sclk_rise), .cnt_q(cnt_q), .word(out_word),
      .sdo_data(sdo_data), .sdo_oe(sdo_oe)
   );

   adcseq_chsel #(.CNT_W(CNT_W), .RST_LO(CH_RST_LO), .RST_HI(CH_RST_HI)) u_chsel (
      .clk(clk), .rst_n(rst_n), .cs_rise(ev.cs_rise), .frame_len(cnt_nxt),
      .channel(channel)
   );

   p_oe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !sdo_oe);
   p_oe_rise_at_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> !$past(cs_n));
   p_samp_conv_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_en && converting));
   p_pd_conv_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(power_down && converting));
   p_void_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sdo_oe) && result_void) |-> !sdo_data);
   p_conv_drop_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !converting);
endmodule

// File: tb/serial_adc_seq_bench.sv
module serial_adc_seq_bench;
   localparam int CLK_P = 10;
   localparam int HALF  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic [11:0] conv_code = '0;
   logic        sdo_data, sdo_oe, sample_en, converting, power_down, channel, result_void;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   serial_adc_seq u_serial_adc_seq (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .conv_code(conv_code),
      .sdo_data(sdo_data), .sdo_oe(sdo_oe), .sample_en(sample_en),
      .converting(converting), .power_down(power_down), .channel(channel),
      .result_void(result_void)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_half();
      repeat (HALF) @(negedge clk);
   endtask

   // one frame of nfalls falling edges; checks R1..R5, R8 inside the frame
   task automatic run_frame(input int nfalls, input logic [11:0] code,
                            input logic [15:0] exp_word, input bit coincide);
      conv_code = code;
      @(negedge clk); cs_n = 1'b0;
      wait_half();
      chk("R1 oe at cs fall", sdo_oe, 1'b1);
      chk("R1 msb at cs fall", sdo_data, exp_word[15]);
      chk("R1 pd cleared", power_down, 1'b0);
      for (int j = 1; j <= nfalls; j++) begin
         @(negedge clk); sclk = 1'b1;
         wait_half();
         if (j <= 16) begin
            chk("R2 serial bit", sdo_data, exp_word[16-j]);
            chk("R3 oe in frame", sdo_oe, 1'b1);
         end else if (j == 17) begin
            chk("R3 oe after 16th", sdo_oe, 1'b0);
         end
         @(negedge clk);
         sclk = 1'b0;
         if (coincide && j == nfalls) cs_n = 1'b1;
         wait_half();
         if (j == 16) conv_code = ~code;
         if (!(coincide && j == nfalls)) begin
            chk("R4 sample window", sample_en, (j >= 4 && j <= 15));
            chk("R5 conversion phase", converting, (j >= 16 && j <= 43));
            chk("R8 power down", power_down, (j >= 44));
         end
      end
      @(negedge clk); cs_n = 1'b1;
      wait_half();
      chk("R3 oe cs high", sdo_oe, 1'b0);
      chk("R8 pd at frame end", power_down, 1'b1);
      chk("R5 idle converting", converting, 1'b0);
      @(negedge clk); sclk = 1'b1; wait_half();
      @(negedge clk); sclk = 1'b0; wait_half();
   endtask

   task automatic t_reset();
      chk("R8 reset pd", power_down, 1'b1);
      chk("R3 reset oe", sdo_oe, 1'b0);
      chk("R4 reset sample", sample_en, 1'b0);
      chk("R9 reset channel", channel, 1'b0);
      chk("R7 reset void", result_void, 1'b0);
   endtask

   task automatic t_full_frames();
      run_frame(44, 12'hA5C, 16'h0000, 1'b0);
      chk("R9 toggle long", channel, 1'b1);
      run_frame(44, 12'h3F1, 16'hA5C0, 1'b0);
      chk("R6 channel back", channel, 1'b0);
   endtask

   task automatic t_abort();
      run_frame(20, 12'h111, 16'h3F10, 1'b0);
      chk("R7 void set", result_void, 1'b1);
      chk("R9 toggle on abort frame", channel, 1'b1);
      run_frame(44, 12'h800, 16'h0000, 1'b0);
      chk("R11 void cleared", result_void, 1'b0);
      chk("R9 toggle", channel, 1'b0);
   endtask

   task automatic t_channel();
      run_frame(10, 12'h123, 16'h8000, 1'b0);
      chk("R9 ten edges toggle", channel, 1'b1);
      run_frame(5, 12'h123, 16'h8000, 1'b0);
      chk("R9 five edges reset", channel, 1'b0);
      run_frame(8, 12'h123, 16'h8000, 1'b0);
      chk("R9 eight edges toggle", channel, 1'b1);
      run_frame(2, 12'h123, 16'h8000, 1'b0);
      chk("R9 two edges hold", channel, 1'b1);
      run_frame(7, 12'h123, 16'h8000, 1'b0);
      chk("R9 seven edges reset", channel, 1'b0);
      chk("R7 short frames keep void low", result_void, 1'b0);
   endtask

   task automatic t_coincide();
      run_frame(44, 12'h6C3, 16'h8000, 1'b1);
      chk("R10 no abort", result_void, 1'b0);
      run_frame(44, 12'h000, 16'h6C30, 1'b0);
      chk("R10 void after", result_void, 1'b0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_full_frames();
      t_abort();
      t_channel();
      t_coincide();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule